// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block watches how long the memory controller has been idle and moves the memory interface into progressively deeper low-power states. One idle count is compared against two programmable thresholds. The shallower threshold enters memory power-down, with or without the memory clock stopped, as chosen by a mode input. The deeper threshold enters self-refresh, where both the memory clock and the controller clock are gated. Any cycle with the idle indication low sends the block back to the active state at once and clears the idle count.

In self-refresh the DLL loses its clock. To keep the DLL close to lock, a hold timer that reloads itself periodically reopens the DLL clock. The clock stays open for a minimum window, and longer if lock has not yet been reported. It is then closed again. Refresh ticks are either serviced during low-power states, by leaving the state for one cycle, or dropped, depending on a control input. All pins are plain level or pulse controls. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `dram_lp_sequencer`

## Requirements
- R1: After reset, every output is low and the block is in the active state.
- R2: With `pd_thresh_i` = N (non-zero), the block asserts `pd_req_o` in the cycle after the N-th consecutive idle cycle. In power-down, `mem_clk_gate_o` equals the value `pd_clk_stop_i` had on the entry cycle.
- R3: With `sr_thresh_i` = M (non-zero), the block asserts `sr_req_o`, `mem_clk_gate_o` and `ctl_clk_gate_o` in the cycle after the M-th consecutive idle cycle, entering either from active or from power-down. Self-refresh wins when both thresholds are reached in the same cycle.
- R4: A threshold of 0 disables entry into its state. With both thresholds at 0, no low-power output rises, however long the idle time.
- R5: A cycle with `idle_i` low returns the block to active in the next cycle and restarts the idle count from zero, so a later entry again needs the full threshold.
- R6: With `ref_block_i` = 0, a `ref_tick_i` during power-down or self-refresh drops all low-power outputs for one cycle, pulses `ref_issue_o` in that cycle, and then returns to the same state. The idle count is not restarted.
- R7: With `ref_block_i` = 1, a `ref_tick_i` during power-down or self-refresh is dropped: `ref_issue_o` stays low and the state is unchanged.
- R8: In the active state, a `ref_tick_i` pulses `ref_issue_o` in the next cycle. A threshold reached in that same cycle has its entry deferred by one cycle.
- R9: In self-refresh with `relock_hold_i` = H, `dll_ungate_o` first rises H+1 cycles after `sr_req_o` rises, and again H+1 cycles after each time it falls.
- R10: Once raised, `dll_ungate_o` stays high for at least 16 cycles, and longer until `dll_locked_i` is seen high. It falls in the cycle after a cycle that meets both conditions.
- R11: When `idle_i` goes low in the same cycle as a `ref_tick_i` during a low-power state, the next cycle is active with `ref_issue_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Controller has no pending work this cycle |
| dll_locked_i | input | 1 | DLL reports lock |
| ref_tick_i | input | 1 | One-cycle refresh request |
| pd_thresh_i | input | CNT_W | Idle cycles before power-down (0 = off) |
| pd_clk_stop_i | input | 1 | Power-down also stops the memory clock |
| sr_thresh_i | input | CNT_W | Idle cycles before self-refresh (0 = off) |
| relock_hold_i | input | CNT_W | Gated cycles between DLL reopen windows |
| ref_block_i | input | 1 | 1 drops refresh ticks while in a low-power state |
| pd_req_o | output | 1 | Memory power-down request |
| sr_req_o | output | 1 | Memory self-refresh request |
| mem_clk_gate_o | output | 1 | Stop the memory clock |
| ctl_clk_gate_o | output | 1 | Stop the controller clock |
| dll_ungate_o | output | 1 | Reopen the DLL clock for re-lock |
| ref_issue_o | output | 1 | Issue one refresh command |

## Verification
Two events can fall in the same cycle. The first is a refresh tick arriving together with a wake (idle dropping) while in self-refresh. The second is a tick arriving on the very cycle an idle threshold is reached in active. The bench drives each pair in one cycle. It then checks that the wake wins and the refresh is still issued, and that the entry slips by exactly one cycle, never overlapping the refresh pulse. A property in the checker also requires that power-down, self-refresh and the refresh strobe are never high together.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [1:0] {
    ST_ACT = 2'd0,
    ST_PD  = 2'd1,
    ST_SR  = 2'd2,
    ST_REF = 2'd3
  } lp_state_e;

  typedef enum logic {
    PH_SHUT = 1'b0,
    PH_OPEN = 1'b1
  } relock_phase_e;

  localparam int unsigned N_LEVELS = 2;
  localparam int unsigned LVL_PD   = 0;
  localparam int unsigned LVL_SR   = 1;
endpackage

// File: rtl/lp_idle_counter.sv
module lp_idle_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idle_i,
  output logic [W:0]   reach_o
);
  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max  = &cnt_q;
  assign reach_o = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!idle_i) cnt_q <= '0;
    else if (!at_max) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lp_thresh_hit.sv
module lp_thresh_hit #(
  parameter int unsigned W = 16
) (
  input  logic [W:0]   reach_i,
  input  logic [W-1:0] thresh_i,
  output logic         hit_o
);
  logic enabled;
  assign enabled = |thresh_i;
  assign hit_o   = enabled && (reach_i >= {1'b0, thresh_i});
endmodule

// File: rtl/lp_relock_timer.sv
module lp_relock_timer import lp_seq_pkg::*; #(
  parameter int unsigned W       = 16,
  parameter int unsigned OPEN_MIN = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] hold_i,
  input  logic         locked_i,
  output logic         ungate_o
);
  localparam int unsigned WIN_W = $clog2(OPEN_MIN) + 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(OPEN_MIN - 1);

  relock_phase_e    phase_q;
  logic [W-1:0]     hold_q;
  logic [WIN_W-1:0] win_q;
  logic             win_done;

  assign win_done = (win_q >= WIN_LAST);
  assign ungate_o = run_i && (phase_q == PH_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SHUT;
      hold_q  <= '0;
      win_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_SHUT;
      hold_q  <= hold_i;
      win_q   <= '0;
    end else if (phase_q == PH_SHUT) begin
      if (hold_q == '0) begin
        phase_q <= PH_OPEN;
        win_q   <= '0;
      end else begin
        hold_q <= hold_q - 1'b1;
      end
    end else begin
      if (win_done && locked_i) begin
        phase_q <= PH_SHUT;
        hold_q  <= hold_i;
        win_q   <= '0;
      end else if (!win_done) begin
        win_q <= win_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_lp_sequencer.sv
module dram_lp_sequencer import lp_seq_pkg::*; #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RELOCK_MIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             dll_locked_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] pd_thresh_i,
  input  logic             pd_clk_stop_i,
  input  logic [CNT_W-1:0] sr_thresh_i,
  input  logic [CNT_W-1:0] relock_hold_i,
  input  logic             ref_block_i,
  output logic             pd_req_o,
  output logic             sr_req_o,
  output logic             mem_clk_gate_o,
  output logic             ctl_clk_gate_o,
  output logic             dll_ungate_o,
  output logic             ref_issue_o
);
  logic [CNT_W:0]                       reach;
  logic [N_LEVELS-1:0][CNT_W-1:0]       thr;
  logic [N_LEVELS-1:0]                  hit;

  lp_state_e state_q, state_d, resume_q, resume_d;
  logic      pd_stop_q, pd_stop_d;
  logic      ref_q, ref_d;
  logic      in_lp;

  lp_idle_counter #(.W(CNT_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_i  (idle_i),
    .reach_o (reach)
  );

  assign thr[LVL_PD] = pd_thresh_i;
  assign thr[LVL_SR] = sr_thresh_i;

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_level
    lp_thresh_hit #(.W(CNT_W)) u_hit (
      .reach_i  (reach),
      .thresh_i (thr[g]),
      .hit_o    (hit[g])
    );
  end

  assign in_lp = (state_q == ST_PD) || (state_q == ST_SR);

  always_comb begin
    state_d   = state_q;
    resume_d  = resume_q;
    pd_stop_d = pd_stop_q;
    unique case (state_q)
      ST_ACT: begin
        if (idle_i && !ref_tick_i) begin
          if (hit[LVL_SR]) begin
            state_d = ST_SR;
          end else if (hit[LVL_PD]) begin
            state_d   = ST_PD;
            pd_stop_d = pd_clk_stop_i;
          end
        end
      end
      ST_PD, ST_SR: begin
        if (!idle_i) begin
          state_d = ST_ACT;
        end else if (ref_tick_i && !ref_block_i) begin
          state_d  = ST_REF;
          resume_d = state_q;
        end else if ((state_q == ST_PD) && hit[LVL_SR]) begin
          state_d = ST_SR;
        end
      end
      ST_REF: begin
        if (!idle_i)          state_d = ST_ACT;
        else if (!ref_tick_i) state_d = resume_q;
      end
      default: state_d = ST_ACT;
    endcase
  end

  assign ref_d = ref_tick_i && (!idle_i || !in_lp || !ref_block_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ACT;
      resume_q  <= ST_PD;
      pd_stop_q <= 1'b0;
      ref_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      resume_q  <= resume_d;
      pd_stop_q <= pd_stop_d;
      ref_q     <= ref_d;
    end
  end

  lp_relock_timer #(.W(CNT_W), .OPEN_MIN(RELOCK_MIN)) u_relock (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (state_q == ST_SR),
    .hold_i   (relock_hold_i),
    .locked_i (dll_locked_i),
    .ungate_o (dll_ungate_o)
  );

  assign pd_req_o       = (state_q == ST_PD);
  assign sr_req_o       = (state_q == ST_SR);
  assign ctl_clk_gate_o = (state_q == ST_SR);
  assign mem_clk_gate_o = (state_q == ST_SR) || ((state_q == ST_PD) && pd_stop_q);
  assign ref_issue_o    = ref_q;
endmodule

// File: rtl/dram_lp_sequencer_chk.sv
module dram_lp_sequencer_chk #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RELOCK_MIN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_i,
  input logic             dll_locked_i,
  input logic [CNT_W-1:0] pd_thresh_i,
  input logic [CNT_W-1:0] sr_thresh_i,
  input logic             ref_block_i,
  input logic             pd_req_o,
  input logic             sr_req_o,
  input logic             mem_clk_gate_o,
  input logic             ctl_clk_gate_o,
  input logic             dll_ungate_o,
  input logic             ref_issue_o
);
  logic [15:0] open_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             open_len_q <= '0;
    else if (!dll_ungate_o) open_len_q <= '0;
    else if (~&open_len_q)  open_len_q <= open_len_q + 1'b1;
  end

  // R6, R8: a refresh pulse never overlaps a low-power request
  p_one_role_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_req_o, sr_req_o, ref_issue_o}));

  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> (!pd_req_o && !sr_req_o));

  p_ctl_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clk_gate_o |-> (sr_req_o && mem_clk_gate_o));

  p_dll_in_sr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dll_ungate_o |-> sr_req_o);

  p_ref_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_req_o || sr_req_o) && idle_i && ref_block_i) |=> !ref_issue_o);

  p_relock_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dll_ungate_o) && sr_req_o) |->
      ((open_len_q >= 16'(RELOCK_MIN)) && $past(dll_locked_i)));

  p_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_thresh_i == '0) && (sr_thresh_i == '0) && !pd_req_o && !sr_req_o && !ref_issue_o)
      |=> (!pd_req_o && !sr_req_o));
endmodule

bind dram_lp_sequencer dram_lp_sequencer_chk #(
  .CNT_W(CNT_W), .RELOCK_MIN(RELOCK_MIN)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .idle_i         (idle_i),
  .dll_locked_i   (dll_locked_i),
  .pd_thresh_i    (pd_thresh_i),
  .sr_thresh_i    (sr_thresh_i),
  .ref_block_i    (ref_block_i),
  .pd_req_o       (pd_req_o),
  .sr_req_o       (sr_req_o),
  .mem_clk_gate_o (mem_clk_gate_o),
  .ctl_clk_gate_o (ctl_clk_gate_o),
  .dll_ungate_o   (dll_ungate_o),
  .ref_issue_o    (ref_issue_o)
);

// File: tb/tb_dram_lp_sequencer.sv
`timescale 1ns/1ps
module tb_dram_lp_sequencer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_i = 1'b0, dll_locked_i = 1'b0, ref_tick_i = 1'b0;
  logic [W-1:0] pd_thresh_i = '0, sr_thresh_i = '0, relock_hold_i = '0;
  logic pd_clk_stop_i = 1'b0, ref_block_i = 1'b0;
  logic pd_req_o, sr_req_o, mem_clk_gate_o, ctl_clk_gate_o, dll_ungate_o, ref_issue_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_lp_sequencer dut (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .dll_locked_i(dll_locked_i),
    .ref_tick_i(ref_tick_i), .pd_thresh_i(pd_thresh_i), .pd_clk_stop_i(pd_clk_stop_i),
    .sr_thresh_i(sr_thresh_i), .relock_hold_i(relock_hold_i), .ref_block_i(ref_block_i),
    .pd_req_o(pd_req_o), .sr_req_o(sr_req_o), .mem_clk_gate_o(mem_clk_gate_o),
    .ctl_clk_gate_o(ctl_clk_gate_o), .dll_ungate_o(dll_ungate_o), .ref_issue_o(ref_issue_o)
  );

  // {idle, tick, lock, pd, sr, mem_gate, ctl_gate, dll, ref}
  // config: pd=3, sr=6, hold=2, pd clock stop on, refresh allowed
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    9'b100_000000, 9'b100_000000, 9'b100_101000, 9'b100_101000,
    9'b110_000001, 9'b100_101000, 9'b100_011100, 9'b100_011100,
    9'b100_011100, 9'b100_011110, 9'b000_000000, 9'b010_000001,
    9'b100_000000
  };

  function automatic logic [5:0] outs();
    return {pd_req_o, sr_req_o, mem_clk_gate_o, ctl_clk_gate_o, dll_ungate_o, ref_issue_o};
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic idle, input logic tick, input logic lock);
    idle_i = idle; ref_tick_i = tick; dll_locked_i = lock;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", outs(), 6'b0);

    // table walk: R2 R3 R5 R6 R8 R9
    pd_thresh_i = 3; sr_thresh_i = 6; relock_hold_i = 2;
    pd_clk_stop_i = 1'b1; ref_block_i = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6]);
      chk($sformatf("R2/R3/R6/R9 vector %0d", i), outs(), VEC[i][5:0]);
    end

    // R5: idle count restarts after a wake
    step(0, 0, 0);
    step(1, 0, 0); step(1, 0, 0);
    chk("R5 two idle after wake", outs(), 6'b0);
    step(1, 0, 0);
    chk("R5 full threshold again", outs(), 6'b101000);

    // R2: power-down without memory clock stop
    step(0, 0, 0);
    pd_clk_stop_i = 1'b0;
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    chk("R2 pd no clock stop", outs(), 6'b100000);

    // R7: blocked refresh in power-down
    ref_block_i = 1'b1;
    step(1, 1, 0);
    chk("R7 tick dropped", outs(), 6'b100000);
    step(1, 0, 0);
    chk("R7 state kept", outs(), 6'b100000);
    ref_block_i = 1'b0;

    // R4: both thresholds zero
    step(0, 0, 0);
    pd_thresh_i = 0; sr_thresh_i = 0;
    for (int i = 0; i < 40; i++) step(1, 0, 0);
    chk("R4 no entry when disabled", outs(), 6'b0);

    // R8: tick in active defers entry by one cycle
    step(0, 0, 0);
    pd_thresh_i = 2; pd_clk_stop_i = 1'b0;
    step(1, 0, 0);
    step(1, 1, 0);
    chk("R8 refresh in active, entry deferred", outs(), 6'b000001);
    step(1, 0, 0);
    chk("R8 entry next cycle", outs(), 6'b100000);

    // R11: wake and tick together in self-refresh
    step(0, 0, 0);
    pd_thresh_i = 0; sr_thresh_i = 2; relock_hold_i = 3;
    step(1, 0, 0); step(1, 0, 0);
    chk("R3 sr entry", outs(), 6'b011100);
    step(0, 1, 0);
    chk("R11 wake with refresh", outs(), 6'b000001);

    // R9, R10: DLL reopen timing, stretch and reload
    step(1, 0, 0); step(1, 0, 0);
    chk("R3 sr re-entry", outs(), 6'b011100);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    chk("R9 still shut before hold ends", outs(), 6'b011100);
    step(1, 0, 0);
    chk("R9 reopen after hold+1", outs(), 6'b011110);
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    chk("R10 window stretched without lock", outs(), 6'b011110);
    step(1, 0, 1);
    chk("R10 regated after lock", outs(), 6'b011100);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    chk("R9 hold reloaded", outs(), 6'b011100);
    step(1, 0, 1);
    chk("R9 reopen again", outs(), 6'b011110);
    begin
      int n_open = 1;
      for (int i = 0; i < 40; i++) begin
        step(1, 0, 1);
        if (dll_ungate_o) n_open++;
        else break;
      end
      chk("R10 minimum window length", 6'(n_open), 6'd16);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule